// File: doc/BRIEF.md
# Serial Command Controller for Voice Playback

This block sits between a host processor and a voice playback engine. The host sends short command frames over three wires: a select line, a serial clock and a data line. The block decodes each frame and carries it out. It sequences the 8-bit output level through power-up and power-down, either jumping at once or stepping one count per sample tick. It can freeze playback and mute the PWM stage. It keeps one group address waiting in a buffer, so that the next group starts in the cycle after the current one finishes.

Three status outputs go back to the host. One is high while the block is occupied, one is high while the address buffer holds a group, and one is a selectable status line. The status line can show the inverse of either flag, one of several tick-derived square waves, or a fast clock taken from the system clock. Decoding the audio itself is left to the engine. The engine receives a one-cycle start request with an address, and it reports completion back through a done pulse.

Top module: `scc_ctrl`

## Requirements
- R1: A frame is every DI bit taken on a rising SCK edge while select is high, most significant bit first. It is acted on only when select falls. One-byte opcodes (C5h, 8Dh, E1h, A9h, 39h, 1Dh) need exactly 8 bits. Two-byte opcodes (E3h, 71h, with the opcode in the first byte) need exactly 16 bits. Frames of any other length, and unknown opcodes, change no output.
- R2: C5h while powered off sets the level to 80h once START_TICKS sample ticks have passed. E1h while powered on sets it to 00h once the same delay has passed.
- R3: 8Dh while off waits the delay and then steps the level from 00h up to 80h, one count per tick. A9h steps it down to 00h the same way, but only if the last power-up was 8Dh. Otherwise A9h acts like E1h. Apart from jumps to 00h or 80h, the level never changes by more than one count at a time.
- R4: BUSY is high during the power delay and the ramps, and while a group is playing. It is low otherwise.
- R5: A group start is issued only while the level is 80h and the block is not paused.
- R6: 71h followed by an address loads the buffer and raises FULL. The group starts when power-up completes, or with no group playing, or in the cycle after a done pulse. The start is a one-cycle pulse carrying the address, and FULL drops at the same edge.
- R7: A 71h frame received while FULL is high is ignored. The buffered address is kept.
- R8: 39h while powered on raises MUTE, holds the level and blocks group starts. 1Dh clears it, and so does an accepted power-down.
- R9: E3h plus a byte whose bits [2:0] select POUT: 000 not-BUSY; 001 to 100 tone-counter bits 0 to 3 (bit 0 toggles on every tick); 101 tone bit TONE_SLOW; 110 a clock toggling every FAST_HALF system clocks; 111 not-FULL. Before the first E3h, POUT is low.
- R10: While paused, the tone counter is frozen. The fast clock keeps running.
- R11: After reset, the level is 00h and BUSY, FULL, MUTE, POUT and the start pulse are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel_i | input | 1 | Host frame select, active high |
| host_sck_i | input | 1 | Host serial clock |
| host_din_i | input | 1 | Host serial data |
| sample_tick_i | input | 1 | One-cycle pulse per audio sample |
| play_done_i | input | 1 | Engine reports that the current group has ended |
| level_o | output | 8 | Output level being sequenced |
| grp_start_o | output | 1 | One-cycle request to start a group |
| grp_addr_o | output | 8 | Group address for the start request |
| busy_o | output | 1 | Power transition or playback in progress |
| full_o | output | 1 | Address buffer occupied |
| pout_o | output | 1 | Selectable status line |
| mute_o | output | 1 | Paused; PWM stage held low |

## Verification
If the power sequencer's state is wrong, it shows on level_o within one sample tick of the command's delay running out. The level either jumps where it should step, or steps where it should jump, or stays at a value other than 00h or 80h while BUSY is low. If the prefetch flag is wrong, the fault shows in the cycle after a done pulse: the start pulse is missing, or FULL stays high, or the start carries an address from a frame that should have been ignored. If the pause flag is wrong, it shows at the next start opportunity, or as tone toggles on POUT during a window that should be quiet.

// File: rtl/scc_pkg.sv
package scc_pkg;
   localparam int LVL_W  = 8;
   localparam int BYTE_W = 8;

   localparam logic [BYTE_W-1:0] OP_PU_FLAT  = 8'hC5;
   localparam logic [BYTE_W-1:0] OP_PU_RAMP  = 8'h8D;
   localparam logic [BYTE_W-1:0] OP_PD_FLAT  = 8'hE1;
   localparam logic [BYTE_W-1:0] OP_PD_RAMP  = 8'hA9;
   localparam logic [BYTE_W-1:0] OP_STATUS   = 8'hE3;
   localparam logic [BYTE_W-1:0] OP_PAUSE    = 8'h39;
   localparam logic [BYTE_W-1:0] OP_RESUME   = 8'h1D;
   localparam logic [BYTE_W-1:0] OP_PREFETCH = 8'h71;

   typedef enum logic [2:0] {
      PW_OFF, PW_WAIT_UP, PW_RAMP_UP, PW_ON, PW_WAIT_DN, PW_RAMP_DN
   } pwr_state_t;

   typedef enum logic [2:0] {
      PS_NBUSY = 3'd0, PS_T0 = 3'd1, PS_T1 = 3'd2, PS_T2 = 3'd3,
      PS_T3 = 3'd4, PS_SLOW = 3'd5, PS_FAST = 3'd6, PS_NFULL = 3'd7
   } pout_sel_t;
endpackage

// File: rtl/scc_rx.sv
module scc_rx
   import scc_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_i,
   input  logic              sck_i,
   input  logic              din_i,
   output logic              frm_one_o,
   output logic              frm_two_o,
   output logic [BYTE_W-1:0] op_o,
   output logic [BYTE_W-1:0] arg_o
);
   localparam int FRM_W = 2 * BYTE_W;
   localparam int CNT_W = $clog2(FRM_W + 2);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("scc_rx: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sel_sy, sck_sy, din_sy;
   logic                   sel_s, sck_s, din_s, sel_q, sck_q;
   logic [FRM_W-1:0]       sr;
   logic [CNT_W-1:0]       cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_sy <= '0;
         sck_sy <= '0;
         din_sy <= '0;
      end else begin
         sel_sy <= {sel_sy[SYNC_STAGES-2:0], sel_i};
         sck_sy <= {sck_sy[SYNC_STAGES-2:0], sck_i};
         din_sy <= {din_sy[SYNC_STAGES-2:0], din_i};
      end
   end

   assign sel_s = sel_sy[SYNC_STAGES-1];
   assign sck_s = sck_sy[SYNC_STAGES-1];
   assign din_s = din_sy[SYNC_STAGES-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q     <= 1'b0;
         sck_q     <= 1'b0;
         sr        <= '0;
         cnt       <= '0;
         frm_one_o <= 1'b0;
         frm_two_o <= 1'b0;
         op_o      <= '0;
         arg_o     <= '0;
      end else begin
         sel_q     <= sel_s;
         sck_q     <= sck_s;
         frm_one_o <= 1'b0;
         frm_two_o <= 1'b0;
         if (sel_s && !sel_q) begin
            cnt <= '0;
         end else if (sel_s && sck_s && !sck_q) begin
            sr <= {sr[FRM_W-2:0], din_s};
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
         end
         if (!sel_s && sel_q) begin
            frm_one_o <= (cnt == CNT_W'(BYTE_W));
            frm_two_o <= (cnt == CNT_W'(FRM_W));
            op_o      <= (cnt == CNT_W'(FRM_W)) ? sr[FRM_W-1:BYTE_W] : sr[BYTE_W-1:0];
            arg_o     <= sr[BYTE_W-1:0];
         end
      end
   end
endmodule

// File: rtl/scc_power.sv
module scc_power
   import scc_pkg::*;
#(
   parameter int               START_TICKS = 2,
   parameter logic [LVL_W-1:0] LVL_ON      = 8'h80
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             pu_i,
   input  logic             pd_i,
   input  logic             ramp_i,
   output logic [LVL_W-1:0] level_o,
   output logic             on_o,
   output logic             busy_o
);
   localparam int DLY_W = $clog2(START_TICKS + 1);
   localparam logic [DLY_W-1:0] DLY_INIT = DLY_W'(START_TICKS);

   if (START_TICKS < 1) begin : g_bad_dly
      $error("scc_power: START_TICKS must be at least 1");
   end
   if (LVL_ON == '0) begin : g_bad_on
      $error("scc_power: LVL_ON must be nonzero");
   end

   pwr_state_t       st;
   logic [DLY_W-1:0] dly;
   logic             want_ramp, ramp_used;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= PW_OFF;
         dly       <= '0;
         want_ramp <= 1'b0;
         ramp_used <= 1'b0;
         level_o   <= '0;
      end else begin
         unique case (st)
            PW_OFF: if (pu_i) begin
               st        <= PW_WAIT_UP;
               dly       <= DLY_INIT;
               want_ramp <= ramp_i;
               ramp_used <= ramp_i;
            end
            PW_WAIT_UP: if (tick_i) begin
               if (dly == DLY_W'(1)) begin
                  if (want_ramp) st <= PW_RAMP_UP;
                  else begin
                     level_o <= LVL_ON;
                     st      <= PW_ON;
                  end
               end else dly <= dly - 1'b1;
            end
            PW_RAMP_UP: if (tick_i) begin
               level_o <= level_o + 1'b1;
               if (level_o == LVL_ON - 1'b1) st <= PW_ON;
            end
            PW_ON: if (pd_i) begin
               st        <= PW_WAIT_DN;
               dly       <= DLY_INIT;
               want_ramp <= ramp_i & ramp_used;
            end
            PW_WAIT_DN: if (tick_i) begin
               if (dly == DLY_W'(1)) begin
                  if (want_ramp) st <= PW_RAMP_DN;
                  else begin
                     level_o <= '0;
                     st      <= PW_OFF;
                  end
               end else dly <= dly - 1'b1;
            end
            PW_RAMP_DN: if (tick_i) begin
               level_o <= level_o - 1'b1;
               if (level_o == LVL_W'(1)) st <= PW_OFF;
            end
            default: st <= PW_OFF;
         endcase
      end
   end

   assign on_o   = (st == PW_ON);
   assign busy_o = (st != PW_ON) && (st != PW_OFF);
endmodule

// File: rtl/scc_pout.sv
module scc_pout
   import scc_pkg::*;
#(
   parameter int TONE_SLOW = 8,
   parameter int FAST_HALF = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       freeze_i,
   input  logic       load_i,
   input  logic [2:0] sel_i,
   input  logic       busy_i,
   input  logic       full_i,
   output logic       pout_o
);
   localparam int TONE_W = TONE_SLOW + 1;

   if (TONE_SLOW < 4) begin : g_bad_slow
      $error("scc_pout: TONE_SLOW must be at least 4");
   end
   if (FAST_HALF < 1) begin : g_bad_fast
      $error("scc_pout: FAST_HALF must be at least 1");
   end

   logic [TONE_W-1:0] tone;
   logic              fclk, set_q;
   pout_sel_t         sel_q;

   always_ff @(posedge clk) begin
      if (!rst_n) tone <= '0;
      else if (tick_i && !freeze_i) tone <= tone + 1'b1;
   end

   if (FAST_HALF == 1) begin : g_fast_direct
      always_ff @(posedge clk) begin
         if (!rst_n) fclk <= 1'b0;
         else        fclk <= ~fclk;
      end
   end else begin : g_fast_div
      localparam int FD_W = $clog2(FAST_HALF);
      logic [FD_W-1:0] fdiv;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            fdiv <= '0;
            fclk <= 1'b0;
         end else if (fdiv == FD_W'(FAST_HALF - 1)) begin
            fdiv <= '0;
            fclk <= ~fclk;
         end else fdiv <= fdiv + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         set_q  <= 1'b0;
         sel_q  <= PS_NBUSY;
         pout_o <= 1'b0;
      end else begin
         if (load_i) begin
            set_q <= 1'b1;
            sel_q <= pout_sel_t'(sel_i);
         end
         if (!set_q) pout_o <= 1'b0;
         else begin
            unique case (sel_q)
               PS_NBUSY: pout_o <= ~busy_i;
               PS_T0:    pout_o <= tone[0];
               PS_T1:    pout_o <= tone[1];
               PS_T2:    pout_o <= tone[2];
               PS_T3:    pout_o <= tone[3];
               PS_SLOW:  pout_o <= tone[TONE_SLOW];
               PS_FAST:  pout_o <= fclk;
               PS_NFULL: pout_o <= ~full_i;
               default:  pout_o <= 1'b0;
            endcase
         end
      end
   end
endmodule

// File: rtl/scc_ctrl.sv
module scc_ctrl
   import scc_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int START_TICKS = 2,
   parameter int TONE_SLOW   = 8,
   parameter int FAST_HALF   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_sel_i,
   input  logic              host_sck_i,
   input  logic              host_din_i,
   input  logic              sample_tick_i,
   input  logic              play_done_i,
   output logic [LVL_W-1:0]  level_o,
   output logic              grp_start_o,
   output logic [BYTE_W-1:0] grp_addr_o,
   output logic              busy_o,
   output logic              full_o,
   output logic              pout_o,
   output logic              mute_o
);
   logic              frm_one, frm_two, pwr_on, pwr_busy;
   logic [BYTE_W-1:0] op, arg, buf_addr;
   logic              cmd_pu, cmd_pd, cmd_ramp, cmd_pause, cmd_resume;
   logic              cmd_status, cmd_pf, start_now, playing, paused;

   scc_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .sel_i(host_sel_i), .sck_i(host_sck_i),
      .din_i(host_din_i), .frm_one_o(frm_one), .frm_two_o(frm_two),
      .op_o(op), .arg_o(arg)
   );

   assign cmd_pu     = frm_one && (op == OP_PU_FLAT || op == OP_PU_RAMP);
   assign cmd_pd     = frm_one && (op == OP_PD_FLAT || op == OP_PD_RAMP);
   assign cmd_ramp   = (op == OP_PU_RAMP) || (op == OP_PD_RAMP);
   assign cmd_pause  = frm_one && (op == OP_PAUSE) && pwr_on;
   assign cmd_resume = frm_one && (op == OP_RESUME);
   assign cmd_status = frm_two && (op == OP_STATUS);
   assign cmd_pf     = frm_two && (op == OP_PREFETCH);

   scc_power #(.START_TICKS(START_TICKS), .LVL_ON(8'h80)) u_power (
      .clk(clk), .rst_n(rst_n), .tick_i(sample_tick_i), .pu_i(cmd_pu),
      .pd_i(cmd_pd), .ramp_i(cmd_ramp), .level_o(level_o),
      .on_o(pwr_on), .busy_o(pwr_busy)
   );

   assign start_now = full_o && pwr_on && !paused && (!playing || play_done_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         paused      <= 1'b0;
         playing     <= 1'b0;
         full_o      <= 1'b0;
         buf_addr    <= '0;
         grp_start_o <= 1'b0;
         grp_addr_o  <= '0;
      end else begin
         if ((cmd_pd && pwr_on) || cmd_resume) paused <= 1'b0;
         else if (cmd_pause)                   paused <= 1'b1;

         grp_start_o <= start_now;
         if (start_now) begin
            grp_addr_o <= buf_addr;
            full_o     <= 1'b0;
            playing    <= 1'b1;
         end else begin
            if (play_done_i) playing <= 1'b0;
            if (cmd_pf && !full_o) begin
               buf_addr <= arg;
               full_o   <= 1'b1;
            end
         end
      end
   end

   assign busy_o = pwr_busy || playing;
   assign mute_o = paused;

   scc_pout #(.TONE_SLOW(TONE_SLOW), .FAST_HALF(FAST_HALF)) u_pout (
      .clk(clk), .rst_n(rst_n), .tick_i(sample_tick_i), .freeze_i(paused),
      .load_i(cmd_status), .sel_i(arg[2:0]), .busy_i(busy_o),
      .full_i(full_o), .pout_o(pout_o)
   );
endmodule

// File: rtl/scc_ctrl_chk.sv
module scc_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] level_o,
   input logic       grp_start_o,
   input logic       busy_o,
   input logic       full_o,
   input logic       mute_o
);
   AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (level_o != $past(level_o)) |-> (level_o == $past(level_o) + 8'd1 || level_o == $past(level_o) - 8'd1 || level_o == 8'h80 || level_o == 8'h00)); // R3
   AST_BUSY_MIDLEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (level_o != 8'h00 && level_o != 8'h80) |-> busy_o); // R4
   AST_START_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
      grp_start_o |-> (level_o == 8'h80) && !$past(mute_o)); // R5
   AST_START_TAKES_BUF: assert property (@(posedge clk) disable iff (!rst_n)
      grp_start_o |-> !full_o && $past(full_o)); // R6
   AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (mute_o && $past(mute_o)) |-> $stable(level_o)); // R8
endmodule

bind scc_ctrl scc_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .level_o(level_o), .grp_start_o(grp_start_o),
   .busy_o(busy_o), .full_o(full_o), .mute_o(mute_o)
);

// File: tb/scc_ctrl_bench.sv
module scc_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel = 1'b0, sck = 1'b0, din = 1'b0, tick = 1'b0, done = 1'b0;
   logic [7:0] level, addr;
   logic       start, busy, full, pout, mute;
   int         n_chk = 0, n_bad = 0, n_start = 0, tdiv = 0;
   logic [7:0] last_addr = '0;

   always #4 clk = ~clk;

   scc_ctrl u_scc_ctrl (
      .clk(clk), .rst_n(rst_n), .host_sel_i(sel), .host_sck_i(sck),
      .host_din_i(din), .sample_tick_i(tick), .play_done_i(done),
      .level_o(level), .grp_start_o(start), .grp_addr_o(addr),
      .busy_o(busy), .full_o(full), .pout_o(pout), .mute_o(mute)
   );

   // sample tick every 4 clocks, start monitor, both at falling edge
   initial forever begin
      @(negedge clk);
      tdiv = tdiv + 1;
      tick = (tdiv % 4 == 0);
      if (start) begin
         n_start = n_start + 1;
         last_addr = addr;
      end
   end

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
   end

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_chk = n_chk + 1;
      if (act != exp) begin
         n_bad = n_bad + 1;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
      n_chk = n_chk + 1;
      if (act < lo || act > hi) begin
         n_bad = n_bad + 1;
         $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
      end
   endtask

   task automatic send(input logic [15:0] data, input int nbits);
      sel = 1'b1;
      wclk(4);
      for (int i = nbits - 1; i >= 0; i--) begin
         din = data[i];
         wclk(3);
         sck = 1'b1;
         wclk(3);
         sck = 1'b0;
      end
      wclk(3);
      sel = 1'b0;
      wclk(6);
   endtask

   task automatic toggles(input int n, output int cnt);
      logic prev;
      cnt = 0;
      prev = pout;
      repeat (n) begin
         @(negedge clk);
         if (pout != prev) cnt++;
         prev = pout;
      end
   endtask

   task automatic pulse_done();
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
   endtask

   // {nbits[4:0], data[15:0], level[7:0], busy, full, mute}
   localparam int NSTEP = 11;
   localparam logic [31:0] STEPS [NSTEP] = '{
      {5'd8,  16'h00C5, 8'h80, 3'b000},  // R2 flat power-up
      {5'd8,  16'h0039, 8'h80, 3'b001},  // R8 pause
      {5'd8,  16'h001D, 8'h80, 3'b000},  // R8 resume
      {5'd8,  16'h00A9, 8'h00, 3'b000},  // R3 ramp-down after flat power-up acts flat
      {5'd8,  16'h008D, 8'h80, 3'b000},  // R3 ramped power-up
      {5'd8,  16'h0039, 8'h80, 3'b001},  // R8 pause again
      {5'd8,  16'h00E1, 8'h00, 3'b000},  // R2 flat power-down releases pause
      {5'd16, 16'h7105, 8'h00, 3'b010},  // R6 prefetch while off
      {5'd8,  16'h0000, 8'h00, 3'b010},  // R1 unknown opcode
      {5'd5,  16'h0018, 8'h00, 3'b010},  // R1 truncated frame
      {5'd16, 16'hC500, 8'h00, 3'b010}   // R1 one-byte opcode in 16-bit frame
   };
   localparam string STEP_TAG [NSTEP] = '{
      "R2", "R8", "R8", "R3", "R3", "R8", "R2", "R6", "R1", "R1", "R1"
   };

   initial begin
      int c;
      wclk(5);
      rst_n = 1'b1;
      wclk(2);
      chk("R11 level", level, 0);
      chk("R11 busy", busy, 0);
      chk("R11 full", full, 0);
      chk("R11 mute", mute, 0);
      chk("R11 start", start, 0);
      chk("R9 pout before status", pout, 0);

      for (int s = 0; s < NSTEP; s++) begin
         send(STEPS[s][26:11], int'(STEPS[s][31:27]));
         wclk(700);
         chk({STEP_TAG[s], " level"}, level, STEPS[s][10:3]);
         chk({STEP_TAG[s], " busy"}, busy, STEPS[s][2]);
         chk({STEP_TAG[s], " full"}, full, STEPS[s][1]);
         chk({STEP_TAG[s], " mute"}, mute, STEPS[s][0]);
      end
      chk("R5 no start while off", n_start, 0);

      // ramped power-up with buffered group
      send(16'h008D, 8);
      wclk(4);
      chk("R4 busy in delay", busy, 1);
      wclk(250);
      chk_rng("R3 ramp-up midway", level, 1, 127);
      chk("R4 busy in ramp", busy, 1);
      wclk(500);
      chk("R3 ramp-up end", level, 8'h80);
      chk("R6 start after power-up", n_start, 1);
      chk("R6 buffered addr", last_addr, 8'h05);
      chk("R6 full cleared", full, 0);
      chk("R4 busy while playing", busy, 1);

      // prefetch, ignored prefetch, gapless chain
      send(16'h7122, 16);
      chk("R6 full set", full, 1);
      send(16'h7133, 16);
      chk("R7 full kept", full, 1);
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
      chk("R6 gapless start", start, 1);
      chk("R7 addr kept", addr, 8'h22);
      chk("R6 full drops", full, 0);
      wclk(2);
      pulse_done();
      wclk(4);
      chk("R4 idle busy low", busy, 0);

      // status selections
      send(16'hE301, 16);
      toggles(256, c);
      chk_rng("R9 tone bit0", c, 63, 65);
      send(16'hE302, 16);
      toggles(256, c);
      chk_rng("R9 tone bit1", c, 31, 33);
      send(16'hE306, 16);
      toggles(256, c);
      chk_rng("R9 fast clock", c, 127, 129);
      send(16'hE300, 16);
      wclk(2);
      chk("R9 not-busy", pout, 1);
      send(16'hE307, 16);
      wclk(2);
      chk("R9 not-full empty", pout, 1);

      // pause blocks start and freezes tones
      send(16'h0039, 8);
      chk("R8 mute", mute, 1);
      send(16'h7144, 16);
      wclk(50);
      chk("R8 full while paused", full, 1);
      chk("R8 no start while paused", n_start, 2);
      chk("R9 not-full when full", pout, 0);
      send(16'hE301, 16);
      toggles(256, c);
      chk("R10 tone frozen", c, 0);
      send(16'hE306, 16);
      toggles(256, c);
      chk_rng("R10 fast runs", c, 127, 129);
      chk("R8 level held", level, 8'h80);

      send(16'h001D, 8);
      wclk(4);
      chk("R8 resume start", n_start, 3);
      chk("R8 resume addr", last_addr, 8'h44);
      chk("R8 mute clear", mute, 0);
      pulse_done();
      wclk(4);

      // ramped power-down
      send(16'h00A9, 8);
      wclk(250);
      chk_rng("R3 ramp-down midway", level, 1, 127);
      chk("R4 busy ramp-down", busy, 1);
      wclk(600);
      chk("R3 ramp-down end", level, 0);
      chk("R4 busy after off", busy, 0);
      summary();
   end
endmodule